// File: doc/BRIEF.md
# Array queue lock manager

This block arbitrates one shared resource among a fixed set of requesters with an array-based queue lock. A requester asks for the lock with a one-cycle acquire pulse. The manager atomically reads the shared tail counter and advances it, and the value read becomes the requester's slot. The requester then waits on the flag of its own slot only, never on a common lock word. Exactly one slot flag is set at any time. The requester whose slot carries that flag is granted the lock.

When the holder releases, its own flag is cleared and the flag of the following slot (wrapping modulo the requester count) is set. Only the requester that took the next ticket sees a change, so hand-off is strictly first-come first-served. The slot array holds one flag per requester, so its storage scales with the requester count. That count must be a power of two so the tail wraps by bit truncation.

Top module: `aql_lock_unit`

## Requirements
- R1: After reset, slot_flags has only bit 0 set, tail_idx is 0, every grant bit is 0 and err_ovf is 0.
- R2: An acquire pulse from an idle requester takes the current tail_idx as its slot, and tail_idx advances by one per accepted acquire, wrapping from NREQ-1 to 0.
- R3: At most one grant bit is high in any cycle, and a grant stays high until its owner releases.
- R4: A release by the holder of slot s clears flag s and sets flag (s+1) mod NREQ at that clock edge, so that exactly one slot flag is set at all times. No other flag changes.
- R5: Acquires that arrive in the same cycle are served in ascending requester index order, taking consecutive tail values. The lowest index gets the current tail.
- R6: A waiting requester whose slot flag was set before a clock edge has its grant bit rise at that edge, so grants follow ticket order. A requester acquiring while its slot flag is already set is granted on the second edge after the pulse.
- R7: An acquire from a requester that is already waiting or holding is an overflow. err_ovf is high for the cycle after that edge, and the acquire neither advances tail_idx nor changes that requester's ticket.
- R8: A release pulse from a requester that does not hold the lock is ignored, and slot_flags and all grants are unchanged by it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| acq_req | input | NREQ | One-cycle acquire pulse per requester |
| rel_req | input | NREQ | One-cycle release pulse per requester |
| grant | output | NREQ | Lock held, one bit per requester |
| slot_flags | output | NREQ | Slot array: bit s set means slot s may proceed |
| tail_idx | output | log2(NREQ) | Next ticket value to be handed out |
| err_ovf | output | 1 | Overflow: acquire from a requester that already has a ticket |

## Verification
On every cycle, the assertions check that the slot array keeps exactly one flag and that grants are mutually exclusive. They also check that a holder's own slot flag is set, that the tail stays still without acquires, and that overflow and stray releases are handled as required. Only the bench's scenarios can show that grants follow ticket order across many hand-offs. The same holds for same-cycle acquires taking consecutive tickets in index order, and for the tail wrapping correctly over long mixed sequences. A pseudo-random sweep on a four-requester configuration compares every port each cycle against an arithmetic model of tickets, flags and states.

// File: rtl/aql_pkg.sv
package aql_pkg;

    typedef enum logic [1:0] {
        RQ_IDLE = 2'd0,
        RQ_WAIT = 2'd1,
        RQ_HOLD = 2'd2
    } rq_state_e;

endpackage

// File: rtl/aql_ticket_alloc.sv
module aql_ticket_alloc #(
    parameter int NREQ = 4,
    parameter int SW   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREQ-1:0]    acq_req,
    input  logic [NREQ-1:0]    busy,
    output logic [NREQ-1:0]    accept,
    output logic [NREQ*SW-1:0] ticket_flat,
    output logic [SW-1:0]      tail_o,
    output logic               err_o
);

    typedef struct packed {
        logic [SW-1:0] tail;
        logic          err;
    } alloc_st_t;

    alloc_st_t st_d, st_q;

    // Serialize same-cycle acquires: lower index draws the lower ticket.
    always_comb begin
        logic [SW-1:0] run;
        st_d = st_q;
        run  = st_q.tail;
        for (int i = 0; i < NREQ; i++) begin
            accept[i]             = acq_req[i] & ~busy[i];
            ticket_flat[i*SW +: SW] = run;
            if (accept[i]) begin
                run = run + 1'b1;
            end
        end
        st_d.tail = run;
        st_d.err  = |(acq_req & busy);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tail_o = st_q.tail;
    assign err_o  = st_q.err;

    // R2: without any acquire the tail does not move
    a_r2_tail_still: assert property (@(posedge clk) disable iff (!rst_n)
        (acq_req == '0) |=> $stable(st_q.tail))
        else $error("tail moved without acquire");

    // R7: an acquire from a busy requester raises the overflow flag
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ((acq_req & busy) != '0) |=> err_o)
        else $error("overflow not flagged");

endmodule

// File: rtl/aql_slot_array.sv
module aql_slot_array #(
    parameter int NREQ = 4,
    parameter int SW   = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NREQ-1:0]    rel_fire,
    input  logic [NREQ*SW-1:0] rel_slot_flat,
    output logic [NREQ-1:0]    flags_o
);

    typedef struct packed {
        logic [NREQ-1:0] flags;
    } slot_st_t;

    slot_st_t st_d, st_q;

    // Clear the releasing slot first, then hand the flag to its successor.
    always_comb begin
        logic [SW-1:0] own;
        logic [SW-1:0] nxt;
        st_d = st_q;
        for (int i = 0; i < NREQ; i++) begin
            own = rel_slot_flat[i*SW +: SW];
            nxt = own + 1'b1;
            if (rel_fire[i]) begin
                st_d.flags[own] = 1'b0;
                st_d.flags[nxt] = 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.flags <= {{(NREQ-1){1'b0}}, 1'b1};
        end else begin
            st_q <= st_d;
        end
    end

    assign flags_o = st_q.flags;

    // R4: the array always carries exactly one proceed flag
    a_r4_single_flag: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(st_q.flags) == 1)
        else $error("slot array lost its single flag");

    // R4: a release always changes the flag vector
    a_r4_release_moves: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_fire != '0) |=> !$stable(st_q.flags))
        else $error("release left flags unchanged");

endmodule

// File: rtl/aql_requester.sv
module aql_requester #(
    parameter int NREQ = 4,
    parameter int SW   = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            accept,
    input  logic [SW-1:0]   ticket,
    input  logic            rel_req,
    input  logic [NREQ-1:0] flags,
    output logic            grant,
    output logic            busy,
    output logic            rel_fire,
    output logic [SW-1:0]   slot
);

    import aql_pkg::*;

    typedef struct packed {
        rq_state_e     st;
        logic [SW-1:0] slot;
    } rq_st_t;

    rq_st_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        rel_fire = (st_q.st == RQ_HOLD) && rel_req;
        case (st_q.st)
            RQ_IDLE: begin
                if (accept) begin
                    st_d.st   = RQ_WAIT;
                    st_d.slot = ticket;
                end
            end
            RQ_WAIT: begin
                if (flags[st_q.slot]) begin
                    st_d.st = RQ_HOLD;
                end
            end
            RQ_HOLD: begin
                if (rel_req) begin
                    st_d.st = RQ_IDLE;
                end
            end
            default: st_d.st = RQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '{st: RQ_IDLE, slot: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign grant = (st_q.st == RQ_HOLD);
    assign busy  = (st_q.st != RQ_IDLE);
    assign slot  = st_q.slot;

    // R6: a holder's own slot carries the proceed flag
    a_r6_grant_has_flag: assert property (@(posedge clk) disable iff (!rst_n)
        grant |-> flags[st_q.slot])
        else $error("grant without slot flag");

    // R8: a release from a waiter does not drop its ticket
    a_r8_stray_release: assert property (@(posedge clk) disable iff (!rst_n)
        (rel_req && st_q.st == RQ_WAIT) |=> busy)
        else $error("waiter lost ticket on stray release");

    // R3: a grant persists until its owner releases
    a_r3_grant_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (grant && !rel_req) |=> grant)
        else $error("grant dropped without release");

endmodule

// File: rtl/aql_lock_unit.sv
module aql_lock_unit #(
    parameter int NREQ = 4,
    localparam int SW  = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREQ-1:0] acq_req,
    input  logic [NREQ-1:0] rel_req,
    output logic [NREQ-1:0] grant,
    output logic [NREQ-1:0] slot_flags,
    output logic [SW-1:0]   tail_idx,
    output logic            err_ovf
);

    logic [NREQ-1:0]    busy;
    logic [NREQ-1:0]    accept;
    logic [NREQ-1:0]    rel_fire;
    logic [NREQ*SW-1:0] ticket_flat;
    logic [NREQ*SW-1:0] slot_flat;

    aql_ticket_alloc #(.NREQ(NREQ), .SW(SW)) u_alloc (
        .clk         (clk),
        .rst_n       (rst_n),
        .acq_req     (acq_req),
        .busy        (busy),
        .accept      (accept),
        .ticket_flat (ticket_flat),
        .tail_o      (tail_idx),
        .err_o       (err_ovf)
    );

    aql_slot_array #(.NREQ(NREQ), .SW(SW)) u_slots (
        .clk           (clk),
        .rst_n         (rst_n),
        .rel_fire      (rel_fire),
        .rel_slot_flat (slot_flat),
        .flags_o       (slot_flags)
    );

    for (genvar g = 0; g < NREQ; g++) begin : g_req
        aql_requester #(.NREQ(NREQ), .SW(SW)) u_req (
            .clk      (clk),
            .rst_n    (rst_n),
            .accept   (accept[g]),
            .ticket   (ticket_flat[g*SW +: SW]),
            .rel_req  (rel_req[g]),
            .flags    (slot_flags),
            .grant    (grant[g]),
            .busy     (busy[g]),
            .rel_fire (rel_fire[g]),
            .slot     (slot_flat[g*SW +: SW])
        );
    end

    // R3: mutual exclusion across requesters
    a_r3_one_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant))
        else $error("more than one grant");

endmodule

// File: tb/aql_lock_unit_test.sv
module aql_lock_unit_test;

    localparam int N  = 4;
    localparam int SW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  acq_req = '0;
    logic [N-1:0]  rel_req = '0;
    logic [N-1:0]  grant;
    logic [N-1:0]  slot_flags;
    logic [SW-1:0] tail_idx;
    logic          err_ovf;

    always #5 clk = ~clk;

    aql_lock_unit #(.NREQ(N)) uut (
        .clk(clk), .rst_n(rst_n), .acq_req(acq_req), .rel_req(rel_req),
        .grant(grant), .slot_flags(slot_flags), .tail_idx(tail_idx), .err_ovf(err_ovf)
    );

    int n_chk = 0;
    int n_bad = 0;

    // reference model: 0 idle, 1 waiting, 2 holding
    int           ms[N];
    int           mslot[N];
    int           mtail;
    logic [N-1:0] mflags;
    logic         merr;

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_edge(logic [N-1:0] acq, logic [N-1:0] rel);
        logic [N-1:0] oldf;
        int ns[N];
        oldf = mflags;
        merr = 1'b0;
        for (int i = 0; i < N; i++) begin
            ns[i] = ms[i];
            if (acq[i] && ms[i] != 0) merr = 1'b1;
        end
        for (int i = 0; i < N; i++) begin
            if (ms[i] == 2 && rel[i]) begin
                mflags[mslot[i]] = 1'b0;
                mflags[(mslot[i] + 1) % N] = 1'b1;
                ns[i] = 0;
            end else if (ms[i] == 1 && oldf[mslot[i]]) begin
                ns[i] = 2;
            end
        end
        for (int i = 0; i < N; i++) begin
            if (acq[i] && ms[i] == 0) begin
                ns[i] = 1;
                mslot[i] = mtail;
                mtail = (mtail + 1) % N;
            end
        end
        for (int i = 0; i < N; i++) ms[i] = ns[i];
    endtask

    function automatic logic [N-1:0] exp_grant();
        logic [N-1:0] g;
        for (int i = 0; i < N; i++) g[i] = (ms[i] == 2);
        return g;
    endfunction

    task automatic check_all(string pfx);
        chk({pfx, " R3 R6 grant"}, int'(grant), int'(exp_grant()));
        chk({pfx, " R4 slot_flags"}, int'(slot_flags), int'(mflags));
        chk({pfx, " R2 R5 tail_idx"}, int'(tail_idx), mtail);
        chk({pfx, " R7 err_ovf"}, int'(err_ovf), int'(merr));
    endtask

    // drive at negedge, sample 1 ns after the rising edge, return at negedge
    task automatic step(logic [N-1:0] acq, logic [N-1:0] rel, string pfx);
        acq_req = acq;
        rel_req = rel;
        @(posedge clk);
        #1;
        model_edge(acq, rel);
        check_all(pfx);
        @(negedge clk);
        acq_req = '0;
        rel_req = '0;
    endtask

    initial begin
        #2_000_000;
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] lf;
        for (int i = 0; i < N; i++) begin ms[i] = 0; mslot[i] = 0; end
        mtail  = 0;
        mflags = 4'b0001;
        merr   = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk("R1 grant", int'(grant), 0);
        chk("R1 slot_flags", int'(slot_flags), 1);
        chk("R1 tail_idx", int'(tail_idx), 0);
        chk("R1 err_ovf", int'(err_ovf), 0);
        @(negedge clk);

        // R2 R6: lone requester 2 takes ticket 0, granted on the second edge
        step(4'b0100, 4'b0000, "R2 single acquire");
        chk("R6 not yet granted", int'(grant), 0);
        step(4'b0000, 4'b0000, "R6 first grant");
        chk("R6 grant to req2", int'(grant), 4'b0100);
        step(4'b0000, 4'b0100, "R4 release");
        chk("R4 flag moved to slot1", int'(slot_flags), 4'b0010);

        // R5: all four acquire together, tickets 1,2,3,0 in index order
        step(4'b1111, 4'b0000, "R5 burst");
        chk("R5 tail wrapped", int'(tail_idx), 1);
        step(4'b0000, 4'b0000, "R5 first served");
        chk("R5 req0 holds", int'(grant), 4'b0001);
        // R8: stray release from a waiter is ignored
        step(4'b0000, 4'b0010, "R8 stray release");
        chk("R8 flags unchanged", int'(slot_flags), 4'b0010);
        chk("R8 grant unchanged", int'(grant), 4'b0001);
        // R7: busy requester acquires again
        step(4'b0010, 4'b0000, "R7 overflow");
        chk("R7 err raised", int'(err_ovf), 1);
        chk("R7 tail unchanged", int'(tail_idx), 1);
        for (int k = 1; k < N; k++) begin
            step(4'b0000, 4'(1 << (k - 1)), "R6 handoff");
            step(4'b0000, 4'b0000, "R6 successor");
            chk("R5 R6 ticket order", int'(grant), 1 << k);
        end
        step(4'b0000, 4'b1000, "R4 last release");

        // near-exhaustive pseudo-random sweep
        lf = 16'hACE1;
        for (int c = 0; c < 4000; c++) begin
            logic [N-1:0] a, r;
            lf = {lf[14:0], lf[15] ^ lf[13] ^ lf[12] ^ lf[10]};
            a = lf[3:0] & lf[7:4];
            r = '0;
            if (lf[8]) r = exp_grant();
            if (lf[12]) r[lf[11:10]] = 1'b1;
            step(a, r, "sweep");
        end

        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule